// File: doc/BRIEF.md
# Indexed Configuration Access Bridge

This block sits between a processor-side register port and two configuration targets: the root port's own register file and the downstream link. Software first writes a bus, device and function number into a selector word. Later accesses that land in a 4 KB data window are passed on as configuration reads or writes to that function, at the window-relative offset. If the selector names bus 0, device 0, the access is sent to the root port's local registers at the same offset and never reaches the link.

Accesses can be 8, 16 or 32 bits wide. The bridge turns the size and the low address bits into byte enables and replicates write data across every byte lane. Read data comes back right-justified. Only one request is in flight at a time. The processor side uses a valid/ready request and a single-cycle response pulse. The downstream side uses a valid/ready request and a response that carries an unsupported-request flag. A mode input chooses how an unsupported-request read completes: as all ones, or as an error.

Top module: `cfg_index_bridge`

## Requirements
- R1: After reset the request port is ready, no response, local or downstream request is active, and the selector reads as 0.
- R2: The selector word sits at byte address 0x9000. It holds bus in bits [27:20], device in bits [19:15] and function in bits [14:12]. All other bits read as 0.
- R3: An access in the window 0x8000–0x8FFF issues one downstream request when the selected bus or device is non-zero. The request carries the selected bus/device/function and the dword-aligned offset (address − 0x8000 with bits [1:0] cleared). Its fields stay stable while it waits for ready.
- R4: When the selector names bus 0 and device 0, whatever the function, a window access becomes one local request at the same dword-aligned offset and issues no downstream request.
- R5: Size code 2 means word, 1 means halfword and 0 means byte. Byte enables are 4'b1111 for a word, 4'b0011 or 4'b1100 by address bit 1 for a halfword, and 4'b0001 shifted by address bits [1:0] for a byte. Write data is the low bytes repeated across all four lanes.
- R6: Read data is the addressed bytes shifted down to bit 0, with the upper bits zero.
- R7: An address outside the window and selector, or size code 3, completes a read with 0xFFFFFFFF and no error. It issues no local or downstream request and leaves the selector unchanged.
- R8: A downstream completion flagged unsupported returns a read as 0xFFFFFFFF with no error when the mode input is 1, and as an error with data 0 when it is 0. An unsupported write always reports an error.
- R9: From the accepting cycle until its response, ready stays low. The response lasts exactly one cycle. The selector does not change while a local or downstream request is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ur_read_ones | input | 1 | 1: unsupported read returns all ones; 0: returns error |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Bridge can accept a request |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | 16 | Byte address in the controller space |
| cpu_req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| cpu_req_wdata | input | 32 | Right-justified write data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_data | output | 32 | Right-justified read data |
| cpu_rsp_err | output | 1 | Completion error |
| loc_req_valid | output | 1 | One-cycle local register access |
| loc_req_write | output | 1 | Local access is a write |
| loc_req_off | output | 12 | Dword-aligned local offset |
| loc_req_be | output | 4 | Local byte enables |
| loc_req_wdata | output | 32 | Lane-replicated local write data |
| loc_rsp_data | input | 32 | Local read word, valid during loc_req_valid |
| ds_req_valid | output | 1 | Downstream configuration request |
| ds_req_ready | input | 1 | Downstream accepts request |
| ds_req_write | output | 1 | Downstream access is a write |
| ds_req_bus | output | 8 | Target bus |
| ds_req_dev | output | 5 | Target device |
| ds_req_fn | output | 3 | Target function |
| ds_req_off | output | 12 | Dword-aligned register offset |
| ds_req_be | output | 4 | Downstream byte enables |
| ds_req_wdata | output | 32 | Lane-replicated write data |
| ds_rsp_valid | input | 1 | Downstream completion |
| ds_rsp_data | input | 32 | Downstream read word |
| ds_rsp_ur | input | 1 | Completion status was unsupported request |

## Verification
The assertions check the handshake rules on every cycle. They confirm that a held downstream request keeps its fields, that local and downstream requests never overlap, that the local path is used only for bus 0/device 0, that byte enables have a legal shape, that the response is a single-cycle pulse with ready low in between, and that the selector stays fixed while a function access is open. Only the bench scenarios can show the data results: the selector packing, the exact offsets and lane steering for each size, right-justified read data, the all-ones result of unroutable accesses, and the two unsupported-request modes. These need chosen addresses and a model of the targets.

// File: rtl/cfgb_pkg.sv
// Shared definitions for the indexed configuration bridge.
// Assumes a 32-bit data path and four byte lanes.
package cfgb_pkg;
    localparam int DATA_W  = 32;
    localparam int BE_W    = DATA_W / 8;
    localparam int BUS_LSB = 20;
    localparam int BUS_W   = 8;
    localparam int DEV_LSB = 15;
    localparam int DEV_W   = 5;
    localparam int FN_LSB  = 12;
    localparam int FN_W    = 3;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    typedef enum logic [1:0] {
        RT_NONE   = 2'd0,
        RT_SELECT = 2'd1,
        RT_LOCAL  = 2'd2,
        RT_REMOTE = 2'd3
    } route_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SEL    = 3'd1,
        ST_LOC    = 3'd2,
        ST_DSREQ  = 3'd3,
        ST_DSWAIT = 3'd4,
        ST_RESP   = 3'd5
    } state_e;
endpackage

// File: rtl/cfgb_route.sv
// Address classifier: decides whether a processor access hits the selector
// word, the data window (and then local or remote), or nothing at all.
// Assumes WIN_BASE is aligned to WIN_BYTES and the selector is word aligned.
module cfgb_route
    import cfgb_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          WIN_BYTES = 4096,
    parameter logic [15:0] WIN_BASE  = 16'h8000,
    parameter logic [15:0] SEL_ADDR  = 16'h9000,
    localparam int         OFF_W     = $clog2(WIN_BYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [BUS_W-1:0]  sel_bus,
    input  logic [DEV_W-1:0]  sel_dev,
    output route_e            route,
    output logic [OFF_W-1:0]  offset
);
    localparam logic [ADDR_W:0] WIN_LO = {1'b0, WIN_BASE[ADDR_W-1:0]};
    localparam logic [ADDR_W:0] WIN_HI = WIN_LO + (ADDR_W+1)'(WIN_BYTES);

    logic in_window;
    logic at_select;
    logic root_self;

    // Classify the address and pick the target for window hits.
    always_comb begin
        in_window = ({1'b0, addr} >= WIN_LO) && ({1'b0, addr} < WIN_HI);
        at_select = (addr[ADDR_W-1:2] == SEL_ADDR[ADDR_W-1:2]);
        root_self = (sel_bus == '0) && (sel_dev == '0);
        offset    = addr[OFF_W-1:0];
        if (size == 2'd3)      route = RT_NONE;
        else if (at_select)    route = RT_SELECT;
        else if (in_window)    route = root_self ? RT_LOCAL : RT_REMOTE;
        else                   route = RT_NONE;
    end
endmodule

// File: rtl/cfgb_lanes.sv
// Byte-lane steering: byte enables and lane-replicated write data from size
// and low address bits, plus right-justification of a returned read word.
// Assumes size codes 0/1/2 = byte/half/word; code 3 yields no enables.
module cfgb_lanes
    import cfgb_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rword,
    output logic [BE_W-1:0]   be,
    output logic [DATA_W-1:0] wlanes,
    output logic [DATA_W-1:0] rjust
);
    logic [1:0]        alo;
    logic [DATA_W-1:0] shifted;

    // Align the low bits to the access size and form enables and write lanes.
    always_comb begin
        alo    = 2'd0;
        be     = '0;
        wlanes = wdata;
        case (size)
            SZ_BYTE: begin
                alo    = lo;
                be     = BE_W'(1) << lo;
                wlanes = {4{wdata[7:0]}};
            end
            SZ_HALF: begin
                alo    = {lo[1], 1'b0};
                be     = lo[1] ? 4'b1100 : 4'b0011;
                wlanes = {2{wdata[15:0]}};
            end
            SZ_WORD: begin
                alo    = 2'd0;
                be     = 4'b1111;
                wlanes = wdata;
            end
            default: begin
                alo    = 2'd0;
                be     = '0;
                wlanes = wdata;
            end
        endcase
    end

    // Shift the addressed bytes down and clear the bytes above the size.
    always_comb begin
        shifted = rword >> {alo, 3'b000};
        case (size)
            SZ_BYTE: rjust = {24'd0, shifted[7:0]};
            SZ_HALF: rjust = {16'd0, shifted[15:0]};
            default: rjust = shifted;
        endcase
    end
endmodule

// File: rtl/cfgb_selector.sv
// Target selector word: holds bus/device/function at fixed bit positions,
// written with byte enables; bits outside the three fields stay zero.
module cfgb_selector
    import cfgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wlanes,
    output logic [DATA_W-1:0] packed_q,
    output logic [BUS_W-1:0]  bus,
    output logic [DEV_W-1:0]  dev,
    output logic [FN_W-1:0]   fn
);
    localparam logic [DATA_W-1:0] FIELD_MASK =
        ((DATA_W'(1) << (BUS_LSB + BUS_W)) - 1) & ~((DATA_W'(1) << FN_LSB) - 1);

    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] merged;

    // Expand byte enables into a bit mask and merge the new lanes.
    always_comb begin
        for (int i = 0; i < BE_W; i++) lane_mask[i*8 +: 8] = {8{be[i]}};
        merged = (packed_q & ~lane_mask) | (wlanes & lane_mask);
    end

    // Hold the selector, keeping only the field bits.
    always_ff @(posedge clk) begin
        if (!rst_n)   packed_q <= '0;
        else if (we)  packed_q <= merged & FIELD_MASK;
    end

    assign bus = packed_q[BUS_LSB +: BUS_W];
    assign dev = packed_q[DEV_LSB +: DEV_W];
    assign fn  = packed_q[FN_LSB  +: FN_W];

    // Reserved selector bits never become set.
    always_comb begin
        if (rst_n) AST_SEL_RSVD_ZERO: assert ((packed_q & ~FIELD_MASK) == '0); // R2
    end
endmodule

// File: rtl/cfg_index_bridge.sv
// Indexed configuration access bridge top. Accepts one processor access at
// a time, routes it to the selector, the local root registers or the
// downstream link, and returns a single-cycle response.
// Assumes the processor takes the response pulse without back-pressure.
module cfg_index_bridge
    import cfgb_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          WIN_BYTES = 4096,
    parameter logic [15:0] WIN_BASE  = 16'h8000,
    parameter logic [15:0] SEL_ADDR  = 16'h9000,
    localparam int         OFF_W     = $clog2(WIN_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ur_read_ones,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_write,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [1:0]        cpu_req_size,
    input  logic [31:0]       cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [31:0]       cpu_rsp_data,
    output logic              cpu_rsp_err,
    output logic              loc_req_valid,
    output logic              loc_req_write,
    output logic [OFF_W-1:0]  loc_req_off,
    output logic [3:0]        loc_req_be,
    output logic [31:0]       loc_req_wdata,
    input  logic [31:0]       loc_rsp_data,
    output logic              ds_req_valid,
    input  logic              ds_req_ready,
    output logic              ds_req_write,
    output logic [7:0]        ds_req_bus,
    output logic [4:0]        ds_req_dev,
    output logic [2:0]        ds_req_fn,
    output logic [OFF_W-1:0]  ds_req_off,
    output logic [3:0]        ds_req_be,
    output logic [31:0]       ds_req_wdata,
    input  logic              ds_rsp_valid,
    input  logic [31:0]       ds_rsp_data,
    input  logic              ds_rsp_ur
);
    state_e            state_q;
    route_e            route;
    logic [OFF_W-1:0]  offset;
    logic              wr_q;
    logic [1:0]        size_q;
    logic [OFF_W-1:0]  off_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rword_q;
    logic              ones_q;
    logic              err_q;
    logic [BE_W-1:0]   be;
    logic [DATA_W-1:0] wlanes;
    logic [DATA_W-1:0] rjust;
    logic [DATA_W-1:0] sel_word;
    logic [BUS_W-1:0]  sel_bus;
    logic [DEV_W-1:0]  sel_dev;
    logic [FN_W-1:0]   sel_fn;
    logic              sel_we;
    logic              accept;

    cfgb_route #(
        .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES),
        .WIN_BASE(WIN_BASE), .SEL_ADDR(SEL_ADDR)
    ) u_route (
        .addr(cpu_req_addr), .size(cpu_req_size),
        .sel_bus(sel_bus), .sel_dev(sel_dev),
        .route(route), .offset(offset)
    );

    cfgb_lanes u_lanes (
        .size(size_q), .lo(off_q[1:0]), .wdata(wdata_q), .rword(rword_q),
        .be(be), .wlanes(wlanes), .rjust(rjust)
    );

    cfgb_selector u_sel (
        .clk(clk), .rst_n(rst_n), .we(sel_we), .be(be), .wlanes(wlanes),
        .packed_q(sel_word), .bus(sel_bus), .dev(sel_dev), .fn(sel_fn)
    );

    assign accept = cpu_req_valid && cpu_req_ready;
    assign sel_we = (state_q == ST_SEL) && wr_q;

    // Sequence one access from acceptance to its response pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            size_q  <= SZ_WORD;
            off_q   <= '0;
            wdata_q <= '0;
            rword_q <= '0;
            ones_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    wr_q    <= cpu_req_write;
                    size_q  <= cpu_req_size;
                    off_q   <= offset;
                    wdata_q <= cpu_req_wdata;
                    rword_q <= '0;
                    err_q   <= 1'b0;
                    ones_q  <= (route == RT_NONE);
                    case (route)
                        RT_SELECT: state_q <= ST_SEL;
                        RT_LOCAL:  state_q <= ST_LOC;
                        RT_REMOTE: state_q <= ST_DSREQ;
                        default:   state_q <= ST_RESP;
                    endcase
                end
                ST_SEL: begin
                    rword_q <= sel_word;
                    state_q <= ST_RESP;
                end
                ST_LOC: begin
                    rword_q <= loc_rsp_data;
                    state_q <= ST_RESP;
                end
                ST_DSREQ: if (ds_req_ready) state_q <= ST_DSWAIT;
                ST_DSWAIT: if (ds_rsp_valid) begin
                    rword_q <= ds_rsp_data;
                    if (ds_rsp_ur) begin
                        if (!wr_q && ur_read_ones) ones_q <= 1'b1;
                        else                       err_q  <= 1'b1;
                    end
                    state_q <= ST_RESP;
                end
                ST_RESP: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the processor-side handshake and response data.
    always_comb begin
        cpu_req_ready = (state_q == ST_IDLE);
        cpu_rsp_valid = (state_q == ST_RESP);
        cpu_rsp_err   = cpu_rsp_valid && err_q;
        if (!cpu_rsp_valid || err_q) cpu_rsp_data = '0;
        else if (ones_q)             cpu_rsp_data = '1;
        else if (wr_q)               cpu_rsp_data = '0;
        else                         cpu_rsp_data = rjust;
    end

    // Drive the local root register access.
    always_comb begin
        loc_req_valid = (state_q == ST_LOC);
        loc_req_write = wr_q;
        loc_req_off   = {off_q[OFF_W-1:2], 2'b00};
        loc_req_be    = be;
        loc_req_wdata = wlanes;
    end

    // Drive the downstream configuration request.
    always_comb begin
        ds_req_valid = (state_q == ST_DSREQ);
        ds_req_write = wr_q;
        ds_req_bus   = sel_bus;
        ds_req_dev   = sel_dev;
        ds_req_fn    = sel_fn;
        ds_req_off   = {off_q[OFF_W-1:2], 2'b00};
        ds_req_be    = be;
        ds_req_wdata = wlanes;
    end

    // Protocol and routing checks.
    AST_DS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_req_valid && !ds_req_ready) |=> (ds_req_valid && $stable(ds_req_off)
            && $stable(ds_req_be) && $stable(ds_req_bus) && $stable(ds_req_wdata))); // R3
    AST_DS_NOT_ROOT: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req_valid |-> !(ds_req_bus == '0 && ds_req_dev == '0)); // R3
    AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ds_req_valid && loc_req_valid)); // R4
    AST_LOC_ROOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        loc_req_valid |-> (sel_word[27:15] == '0)); // R4
    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ds_req_valid |-> (ds_req_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF})); // R5
    AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready); // R9
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> (!cpu_rsp_valid && cpu_req_ready)); // R9
    AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_req_valid || loc_req_valid || state_q == ST_DSWAIT) |=> $stable(sel_word)); // R9
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_err |-> (cpu_rsp_data == '0)); // R8
endmodule

// File: tb/sim_cfg_index_bridge.sv
module sim_cfg_index_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ur_read_ones = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_write = 1'b0;
    logic [15:0] cpu_req_addr = '0;
    logic [1:0]  cpu_req_size = 2'd2;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_rsp_valid;
    logic [31:0] cpu_rsp_data;
    logic        cpu_rsp_err;
    logic        loc_req_valid, loc_req_write;
    logic [11:0] loc_req_off;
    logic [3:0]  loc_req_be;
    logic [31:0] loc_req_wdata;
    logic [31:0] loc_rsp_data;
    logic        ds_req_valid, ds_req_write;
    logic        ds_req_ready = 1'b0;
    logic [7:0]  ds_req_bus;
    logic [4:0]  ds_req_dev;
    logic [2:0]  ds_req_fn;
    logic [11:0] ds_req_off;
    logic [3:0]  ds_req_be;
    logic [31:0] ds_req_wdata;
    logic        ds_rsp_valid = 1'b0;
    logic [31:0] ds_rsp_data = '0;
    logic        ds_rsp_ur = 1'b0;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    cfg_index_bridge u0 (.*);

    // Local register model: readable word encodes its offset.
    assign loc_rsp_data = {20'hC0FFE, loc_req_off};

    // Monitors of requests seen on the target sides.
    int          ds_cnt = 0, loc_cnt = 0;
    logic [7:0]  m_bus; logic [4:0] m_dev; logic [2:0] m_fn;
    logic [11:0] m_off; logic [3:0] m_be; logic [31:0] m_wd; logic m_wr;
    logic [11:0] l_off; logic [3:0] l_be; logic [31:0] l_wd; logic l_wr;
    always @(posedge clk) begin
        if (ds_req_valid && ds_req_ready) begin
            ds_cnt <= ds_cnt + 1;
            m_bus <= ds_req_bus; m_dev <= ds_req_dev; m_fn <= ds_req_fn;
            m_off <= ds_req_off; m_be <= ds_req_be; m_wd <= ds_req_wdata; m_wr <= ds_req_write;
        end
        if (loc_req_valid) begin
            loc_cnt <= loc_cnt + 1;
            l_off <= loc_req_off; l_be <= loc_req_be; l_wd <= loc_req_wdata; l_wr <= loc_req_write;
        end
    end

    function automatic logic [31:0] pat(input logic [7:0] b, input logic [4:0] d,
                                        input logic [2:0] f, input logic [11:0] o);
        return {b, d, f, 4'h0, o};
    endfunction

    // Downstream model: ready after one cycle, completion a few cycles later.
    logic busy = 1'b0;
    int   dly = 0;
    always @(posedge clk) begin
        ds_rsp_valid <= 1'b0;
        if (!rst_n) begin
            busy <= 1'b0; ds_req_ready <= 1'b0;
        end else begin
            ds_req_ready <= ds_req_valid && !ds_req_ready && !busy;
            if (ds_req_valid && ds_req_ready) begin
                busy <= 1'b1; dly <= 3;
                ds_rsp_data <= pat(ds_req_bus, ds_req_dev, ds_req_fn, ds_req_off);
                ds_rsp_ur   <= (ds_req_bus == 8'hEE);
            end else if (busy) begin
                if (dly != 0) dly <= dly - 1;
                else begin ds_rsp_valid <= 1'b1; busy <= 1'b0; end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    logic [31:0] rd;
    logic        er;
    logic        rdy_low;

    task automatic access(input logic w, input logic [15:0] a, input logic [1:0] sz,
                          input logic [31:0] wd);
        int n = 0;
        @(negedge clk);
        while (!cpu_req_ready) @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a;
        cpu_req_size = sz; cpu_req_wdata = wd;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        rdy_low = 1'b1;
        while (!cpu_rsp_valid && n < 1000) begin
            if (cpu_req_ready) rdy_low = 1'b0;
            @(negedge clk);
            n++;
        end
        if (cpu_req_ready) rdy_low = 1'b0;
        if (n >= 1000) check("R9 response timeout", 32'd0, 32'd1);
        rd = cpu_rsp_data;
        er = cpu_rsp_err;
    endtask

    task automatic t_reset;
        check("R1 ready", {31'd0, cpu_req_ready}, 32'd1);
        check("R1 no response", {31'd0, cpu_rsp_valid}, 32'd0);
        check("R1 no target request", {30'd0, ds_req_valid, loc_req_valid}, 32'd0);
        access(1'b0, 16'h9000, 2'd2, 0);
        check("R1 selector zero", rd, 32'd0);
    endtask

    task automatic t_selector;
        access(1'b1, 16'h9000, 2'd2, 32'hFFFF_FFFF);
        access(1'b0, 16'h9000, 2'd2, 0);
        check("R2 reserved bits zero", rd, 32'h0FFF_F000);
        access(1'b1, 16'h9000, 2'd2, (32'd3 << 20) | (32'd4 << 15) | (32'd5 << 12));
        access(1'b0, 16'h9000, 2'd2, 0);
        check("R2 packed fields", rd, 32'h0032_5000);
        access(1'b0, 16'h9002, 2'd0, 0);
        check("R6 byte of selector", rd, 32'h0000_0032);
    endtask

    task automatic t_remote;
        int c0 = ds_cnt;
        access(1'b0, 16'h8010, 2'd2, 0);
        check("R3 word read data", rd, pat(8'd3, 5'd4, 3'd5, 12'h010));
        check("R3 target", {m_bus, 3'd0, m_dev, 5'd0, m_fn, m_off}, {8'd3, 3'd0, 5'd4, 5'd0, 3'd5, 12'h010});
        check("R5 word enables", {28'd0, m_be}, 32'hF);
        check("R3 one request", ds_cnt - c0, 32'd1);
        check("R9 ready low while pending", {31'd0, rdy_low}, 32'd1);
        access(1'b0, 16'h8016, 2'd1, 0);
        check("R5 half enables", {m_off, m_be}, {12'h014, 4'b1100});
        check("R6 half read", rd, {16'd0, pat(8'd3, 5'd4, 3'd5, 12'h014) >> 16});
        access(1'b0, 16'h8107, 2'd0, 0);
        check("R5 byte enables", {m_off, m_be}, {12'h104, 4'b1000});
        check("R6 byte read", rd, {24'd0, pat(8'd3, 5'd4, 3'd5, 12'h104) >> 24});
        access(1'b1, 16'h8021, 2'd0, 32'h0000_00AB);
        check("R5 byte write lanes", m_wd, 32'hABAB_ABAB);
        check("R5 byte write enables", {m_wr, m_off, m_be}, {1'b1, 12'h020, 4'b0010});
        check("R8 clean write no error", {31'd0, er}, 32'd0);
        access(1'b1, 16'h8022, 2'd1, 32'h0000_1234);
        check("R5 half write", {m_wd, m_be}, {32'h1234_1234, 4'b1100});
        access(1'b0, 16'h9000, 2'd2, 0);
        check("R9 selector kept", rd, 32'h0032_5000);
    endtask

    task automatic t_local;
        int c0;
        access(1'b1, 16'h9000, 2'd2, 32'h0000_2000);
        c0 = ds_cnt;
        access(1'b0, 16'h8040, 2'd2, 0);
        check("R4 local read", rd, 32'hC0FF_E040);
        access(1'b1, 16'h8046, 2'd1, 32'h0000_BEEF);
        check("R4 local write", {l_wr, l_off, l_be}, {1'b1, 12'h044, 4'b1100});
        check("R4 local write data", l_wd, 32'hBEEF_BEEF);
        check("R4 no downstream", ds_cnt - c0, 32'd0);
    endtask

    task automatic t_unroutable;
        int c0 = ds_cnt;
        int l0 = loc_cnt;
        access(1'b0, 16'h1234, 2'd0, 0);
        check("R7 outside read ones", rd, 32'hFFFF_FFFF);
        check("R7 no error", {31'd0, er}, 32'd0);
        access(1'b0, 16'h8000, 2'd3, 0);
        check("R7 bad size ones", rd, 32'hFFFF_FFFF);
        access(1'b1, 16'h9000, 2'd3, 32'h0FFF_F000);
        access(1'b1, 16'h2000, 2'd2, 32'h1111_1111);
        check("R7 no target request", (ds_cnt - c0) + (loc_cnt - l0), 32'd0);
        access(1'b0, 16'h9000, 2'd2, 0);
        check("R7 selector unchanged", rd, 32'h0000_2000);
    endtask

    task automatic t_unsupported;
        access(1'b1, 16'h9000, 2'd2, 32'h0EE0_0000);
        ur_read_ones = 1'b0;
        access(1'b0, 16'h8000, 2'd2, 0);
        check("R8 error mode", {er, rd[30:0]}, 32'h8000_0000);
        ur_read_ones = 1'b1;
        access(1'b0, 16'h8004, 2'd1, 0);
        check("R8 ones mode data", rd, 32'hFFFF_FFFF);
        check("R8 ones mode no error", {31'd0, er}, 32'd0);
        access(1'b1, 16'h8008, 2'd2, 32'h5);
        check("R8 write error", {31'd0, er}, 32'd1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_selector();
        t_remote();
        t_local();
        t_unroutable();
        t_unsupported();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule